// File: doc/BRIEF.md
# Chained-Descriptor Transmit DMA Walker

This block is a single-channel transmit DMA engine that works through a linked list of buffer descriptors kept in a word-addressed memory. Software builds a chain of descriptors and sets the hardware-ownership flag in each one. It then writes the address of the first descriptor into the head-pointer register. The engine reads each descriptor and streams the buffer contents as bytes on a valid/ready interface. When a packet is done, it writes the descriptor's mode word back with ownership cleared, and then follows the next pointer.

A descriptor occupies four 32-bit words. Byte offset 0 holds the next-descriptor pointer, where zero means end of chain. Offset 4 holds the buffer pointer. Offset 8 holds the buffer length, which the engine does not read and which is left for software. Offset 12 holds the mode word. Mode-word flags: bit 31 start of packet, bit 30 end of packet, bit 29 hardware owns, bit 28 end of queue (set by the engine). The packet byte count is in bits 10:0 of the mode word.

Software may append to a running chain. If the old tail already shows end of queue, the engine has stopped, and software restarts it by writing the head pointer again. Software acknowledges each finished descriptor by writing its address to the completion-pointer register. The memory port has a fixed one-cycle read latency. Register writes arrive on a simple write strobe.

Top module: `dtx_dma_top`

## Requirements
- R1: After reset, `dma_busy`, `tx_valid`, `srst_busy` and `chan_en` are 0, and `head_ptr` and `cmpl_ptr` are 0.
- R2: While idle, with the enable set and `head_ptr` nonzero, the engine reads the words at descriptor byte offsets 0 (next pointer), 4 (buffer pointer) and 12 (mode word).
- R3: A packet of N bytes, where N is mode-word bits 10:0, is sent as N handshakes. Buffer bytes are taken from each 32-bit word least-significant byte first. `tx_last` is 1 on the final byte only.
- R4: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R5: After the last byte, the engine writes the mode word back to descriptor offset 12 with bit 29 cleared and all other bits kept. If the next pointer is zero, it also sets bit 28, and `head_ptr` becomes 0.
- R6: If the next pointer is nonzero, the engine loads that address into `head_ptr` and processes the next descriptor without software action.
- R7: If a fetched mode word has bit 29 clear, the engine sends no bytes, writes nothing back, clears `head_ptr` and goes idle.
- R8: A head-pointer write (offset 0x8) is ignored while `dma_busy` is 1. While idle it is accepted, and it restarts the engine after an end of queue.
- R9: Enable (offset 0x4, bit 0) gates starting. While it is 0, a written head pointer is kept but nothing is fetched. Clearing it stops the engine at the next descriptor boundary.
- R10: Writing 1 to bit 0 at offset 0x0 sets `srst_busy` for exactly one cycle. In that cycle the engine aborts any transfer and clears the enable, `head_ptr`, `cmpl_ptr` and `tx_valid`.
- R11: A write at offset 0xC loads `cmpl_ptr`, which holds the value until the next such write or a soft reset.
- R12: An owned descriptor with a length of 0 sends no bytes but is still written back as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_rd | output | 1 | Memory read request; data is returned the next cycle |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_last | output | 1 | Final byte of the packet |
| dma_busy | output | 1 | Engine is not idle |
| head_ptr | output | AW | Head-pointer register |
| cmpl_ptr | output | AW | Completion-pointer register |
| srst_busy | output | 1 | Soft reset in progress |
| chan_en | output | 1 | Channel enable |

## Verification
The bench drives packet lengths that are not multiples of four and uses several sink ready patterns. An engine that sends bytes in the wrong order, miscounts the last partial word, or moves `tx_last` would produce a byte stream that disagrees with the computed pattern. It builds a two-descriptor chain and checks that only the tail receives the end-of-queue flag. An engine that skipped the next pointer, or flagged every descriptor, would fail this. Corner cases include:
- a descriptor not owned by hardware, where a wrong engine would transmit stale data or write it back;
- a zero-length packet, where a wrong engine would hang or send a spurious byte;
- a head-pointer write while busy, where a wrong engine would jump to another chain;
- a soft reset in the middle of a packet, where a wrong engine would leave the stream valid or keep its registers.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  localparam int unsigned MODE_SOP = 31;
  localparam int unsigned MODE_EOP = 30;
  localparam int unsigned MODE_OWN = 29;
  localparam int unsigned MODE_EOQ = 28;
  localparam int unsigned LEN_W    = 11;

  localparam logic [3:0] REG_SRST = 4'h0;
  localparam logic [3:0] REG_EN   = 4'h4;
  localparam logic [3:0] REG_HEAD = 4'h8;
  localparam logic [3:0] REG_CMPL = 4'hC;

  localparam int unsigned OFS_NEXT = 0;
  localparam int unsigned OFS_BUF  = 4;
  localparam int unsigned OFS_MODE = 12;

  typedef enum logic [3:0] {
    W_IDLE, W_RD_NEXT, W_RD_BUF, W_RD_MODE, W_CHECK,
    W_DAT_RD, W_DAT_CAP, W_DAT_WAIT, W_WB
  } walk_st_e;
endpackage

// File: rtl/dtx_regs.sv
module dtx_regs
  import dtx_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [3:0]    addr,
  input  logic [31:0]   wdata,
  input  logic          walk_idle,
  input  logic          hd_upd,
  input  logic [AW-1:0] hd_val,
  output logic          srst_q,
  output logic          en_q,
  output logic [AW-1:0] head_q,
  output logic [AW-1:0] cmpl_q
);
  logic          srst_d, en_d;
  logic [AW-1:0] head_d, cmpl_d;
  logic          wr_srst, wr_en, wr_head, wr_cmpl;

  assign wr_srst = wr && (addr == REG_SRST);
  assign wr_en   = wr && (addr == REG_EN);
  assign wr_head = wr && (addr == REG_HEAD);
  assign wr_cmpl = wr && (addr == REG_CMPL);

  always_comb begin
    srst_d = wr_srst && wdata[0] && !srst_q;
    en_d   = en_q;
    head_d = head_q;
    cmpl_d = cmpl_q;
    if (srst_q) begin
      en_d   = 1'b0;
      head_d = '0;
      cmpl_d = '0;
    end else begin
      if (wr_en)                     en_d   = wdata[0];
      if (hd_upd)                    head_d = hd_val;
      else if (wr_head && walk_idle) head_d = wdata[AW-1:0];
      if (wr_cmpl)                   cmpl_d = wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      en_q   <= 1'b0;
      head_q <= '0;
      cmpl_q <= '0;
    end else begin
      srst_q <= srst_d;
      en_q   <= en_d;
      head_q <= head_d;
      cmpl_q <= cmpl_d;
    end
  end

  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q); // R10
  AST_HEAD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_head && !walk_idle && !hd_upd && !srst_q) |=> $stable(head_q)); // R8
  AST_CMPL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmpl && !srst_q) |=> (cmpl_q == $past(wdata[AW-1:0]))); // R11
endmodule

// File: rtl/dtx_ser.sv
module dtx_ser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [2:0]  nb,
  input  logic        last_w,
  input  logic        ready,
  output logic        valid,
  output logic [7:0]  data,
  output logic        last,
  output logic        busy
);
  logic [31:0] word_q;
  logic [1:0]  idx_q;
  logic [2:0]  nb_q;
  logic        lastw_q, busy_q;
  logic        fire, word_end;

  assign fire     = busy_q && ready;
  assign word_end = ({1'b0, idx_q} == (nb_q - 3'd1));
  assign valid    = busy_q;
  assign busy     = busy_q;
  assign data     = word_q[{idx_q, 3'b000} +: 8];
  assign last     = busy_q && lastw_q && word_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      idx_q   <= '0;
      nb_q    <= '0;
      lastw_q <= 1'b0;
      busy_q  <= 1'b0;
    end else if (clr) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
    end else if (load) begin
      word_q  <= word;
      idx_q   <= '0;
      nb_q    <= nb;
      lastw_q <= last_w;
      busy_q  <= 1'b1;
    end else if (fire) begin
      if (word_end) busy_q <= 1'b0;
      else          idx_q  <= idx_q + 2'd1;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (valid && !ready) |=> (valid && $stable(data) && $stable(last))); // R4
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q); // R3
endmodule

// File: rtl/dtx_walker.sv
module dtx_walker
  import dtx_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [AW-1:0] head,
  output logic          idle,
  output logic          hd_upd,
  output logic [AW-1:0] hd_val,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:2] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          ser_load,
  output logic [31:0]   ser_word,
  output logic [2:0]    ser_nb,
  output logic          ser_last,
  input  logic          ser_busy
);
  walk_st_e st_q, st_d;
  logic [AW-1:0]    cur_q, cur_d, nxt_q, buf_q;
  logic [31:0]      mode_q;
  logic [LEN_W-1:0] rem_q;
  logic             ld_cur, cap_next, cap_buf, cap_mode, adv_buf;
  logic [AW-1:0]    a_buf, a_mode;

  assign a_buf    = cur_q + AW'(OFS_BUF);
  assign a_mode   = cur_q + AW'(OFS_MODE);
  assign idle     = (st_q == W_IDLE);
  assign ser_word = mem_rdata;
  assign ser_nb   = (rem_q >= LEN_W'(4)) ? 3'd4 : rem_q[2:0];
  assign ser_last = (rem_q <= LEN_W'(4));

  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    ld_cur    = 1'b0;
    cap_next  = 1'b0;
    cap_buf   = 1'b0;
    cap_mode  = 1'b0;
    adv_buf   = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = cur_q[AW-1:2];
    mem_wdata = '0;
    hd_upd    = 1'b0;
    hd_val    = '0;
    ser_load  = 1'b0;
    unique case (st_q)
      W_IDLE: if (en && (head != '0)) begin
        ld_cur = 1'b1;
        cur_d  = head;
        st_d   = W_RD_NEXT;
      end
      W_RD_NEXT: begin
        mem_rd = 1'b1;
        st_d   = W_RD_BUF;
      end
      W_RD_BUF: begin
        mem_rd   = 1'b1;
        mem_addr = a_buf[AW-1:2];
        cap_next = 1'b1;
        st_d     = W_RD_MODE;
      end
      W_RD_MODE: begin
        mem_rd   = 1'b1;
        mem_addr = a_mode[AW-1:2];
        cap_buf  = 1'b1;
        st_d     = W_CHECK;
      end
      W_CHECK: begin
        cap_mode = 1'b1;
        if (!mem_rdata[MODE_OWN]) begin
          hd_upd = 1'b1;
          st_d   = W_IDLE;
        end else if (mem_rdata[LEN_W-1:0] == '0) begin
          st_d = W_WB;
        end else begin
          st_d = W_DAT_RD;
        end
      end
      W_DAT_RD: begin
        mem_rd   = 1'b1;
        mem_addr = buf_q[AW-1:2];
        st_d     = W_DAT_CAP;
      end
      W_DAT_CAP: begin
        ser_load = 1'b1;
        adv_buf  = 1'b1;
        st_d     = W_DAT_WAIT;
      end
      W_DAT_WAIT: if (!ser_busy) st_d = (rem_q == '0) ? W_WB : W_DAT_RD;
      W_WB: begin
        mem_wr    = 1'b1;
        mem_addr  = a_mode[AW-1:2];
        mem_wdata = mode_q & ~(32'd1 << MODE_OWN);
        mem_wdata[MODE_EOQ] = (nxt_q == '0) | mode_q[MODE_EOQ];
        hd_upd    = 1'b1;
        hd_val    = nxt_q;
        if (nxt_q == '0) begin
          st_d = W_IDLE;
        end else begin
          ld_cur = 1'b1;
          cur_d  = nxt_q;
          st_d   = en ? W_RD_NEXT : W_IDLE;
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= W_IDLE;
    else if (clr) st_q <= W_IDLE;
    else st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      nxt_q  <= '0;
      buf_q  <= '0;
      mode_q <= '0;
      rem_q  <= '0;
    end else begin
      if (ld_cur)   cur_q  <= cur_d;
      if (cap_next) nxt_q  <= mem_rdata[AW-1:0];
      if (cap_buf)  buf_q  <= mem_rdata[AW-1:0];
      if (cap_mode) begin
        mode_q <= mem_rdata;
        rem_q  <= mem_rdata[LEN_W-1:0];
      end
      if (adv_buf) begin
        buf_q <= buf_q + AW'(4);
        rem_q <= rem_q - LEN_W'(ser_nb);
      end
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R2
  AST_EOQ_CLEARS_HEAD: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (mem_wr && mem_wdata[MODE_EOQ] && (nxt_q == '0)) |=> (head == '0)); // R5
  AST_UNOWNED_STOPS: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ((st_q == W_CHECK) && !mem_rdata[MODE_OWN]) |=> (idle && !mem_wr)); // R7
  AST_EN_GATES_START: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (idle && !en) |=> idle); // R9
  AST_IDLE_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !ser_busy); // R12
endmodule

// File: rtl/dtx_dma_top.sv
module dtx_dma_top #(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:2] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_last,
  output logic          dma_busy,
  output logic [AW-1:0] head_ptr,
  output logic [AW-1:0] cmpl_ptr,
  output logic          srst_busy,
  output logic          chan_en
);
  logic          rst_s1, rst_sn;
  logic          srst_q, walk_idle, hd_upd;
  logic [AW-1:0] hd_val;
  logic          ser_load, ser_last, ser_busy;
  logic [31:0]   ser_word;
  logic [2:0]    ser_nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  dtx_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .walk_idle(walk_idle), .hd_upd(hd_upd), .hd_val(hd_val),
    .srst_q(srst_q), .en_q(chan_en), .head_q(head_ptr), .cmpl_q(cmpl_ptr)
  );

  dtx_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_sn), .clr(srst_q), .en(chan_en), .head(head_ptr),
    .idle(walk_idle), .hd_upd(hd_upd), .hd_val(hd_val),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ser_load(ser_load), .ser_word(ser_word), .ser_nb(ser_nb),
    .ser_last(ser_last), .ser_busy(ser_busy)
  );

  dtx_ser u_ser (
    .clk(clk), .rst_n(rst_sn), .clr(srst_q), .load(ser_load), .word(ser_word),
    .nb(ser_nb), .last_w(ser_last), .ready(tx_ready), .valid(tx_valid),
    .data(tx_data), .last(tx_last), .busy(ser_busy)
  );

  assign dma_busy  = !walk_idle;
  assign srst_busy = srst_q;
endmodule

// File: tb/dtx_dma_top_tb.sv
module dtx_dma_top_tb;
  localparam int unsigned AW = 12;
  localparam int unsigned OWN = 32'h2000_0000;
  localparam int unsigned EOQ = 32'h1000_0000;
  localparam int unsigned SE  = 32'hC000_0000;

  // {len[15:0], seed[7:0], ready mode[7:0]}
  localparam logic [31:0] VEC [0:5] = '{
    32'h0001_1100, 32'h0004_2000, 32'h0005_3101,
    32'h0007_4402, 32'h000D_5501, 32'h0003_F000 };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic mem_rd, mem_wr;
  logic [AW-1:2] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, dma_busy, srst_busy, chan_en;
  logic tx_ready = 1'b0;
  logic [AW-1:0] head_ptr, cmpl_ptr;

  logic [31:0] mem [0:1023];
  logic poke_en = 1'b0;
  logic [9:0] poke_a = '0;
  logic [31:0] poke_d = '0;

  int checks = 0, errors = 0;
  int rmode = 0, rcnt = 0, cyc = 0;
  int rx_n = 0, wb_n = 0, stall_err = 0;
  logic [7:0] rx_d [0:2047];
  logic rx_l [0:2047];
  logic [9:0] wb_a;
  logic [31:0] wb_d;
  logic prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  logic prev_last = 1'b0;

  dtx_dma_top #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last), .dma_busy(dma_busy), .head_ptr(head_ptr),
    .cmpl_ptr(cmpl_ptr), .srst_busy(srst_busy), .chan_en(chan_en)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    else if (poke_en) mem[poke_a] <= poke_d;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_valid && tx_ready) begin
      rx_d[rx_n] = tx_data;
      rx_l[rx_n] = tx_last;
      rx_n = rx_n + 1;
    end
    if (mem_wr) begin
      wb_a = mem_addr;
      wb_d = mem_wdata;
      wb_n = wb_n + 1;
    end
    if (prev_stall && !srst_busy &&
        (!tx_valid || tx_data != prev_data || tx_last != prev_last))
      stall_err = stall_err + 1;
    prev_stall = tx_valid && !tx_ready && !srst_busy;
    prev_data  = tx_data;
    prev_last  = tx_last;
  end

  always @(negedge clk) begin
    rcnt = rcnt + 1;
    case (rmode)
      0: tx_ready = 1'b1;
      1: tx_ready = rcnt[0];
      2: tx_ready = (rcnt % 3) == 0;
      default: tx_ready = 1'b0;
    endcase
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic poke(input int baddr, input logic [31:0] d);
    poke_en = 1'b1; poke_a = 10'(baddr >> 2); poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic regw(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic build(input int desc, input int nxt, input int bufp, input int len,
                       input logic [7:0] seed, input bit own);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] word;
      for (int b = 0; b < 4; b++) word[8*b +: 8] = seed + 8'(4*w + b);
      poke(bufp + 4*w, word);
    end
    poke(desc, 32'(nxt));
    poke(desc + 4, 32'(bufp));
    poke(desc + 8, 32'(len));
    poke(desc + 12, SE | (own ? OWN : 0) | 32'(len));
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk); @(negedge clk);
    while (dma_busy && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic chk_bytes(input int base, input int len, input logic [7:0] seed,
                           input bit last_at_end, input string req);
    for (int i = 0; i < len; i++) begin
      chk(rx_d[base+i] == seed + 8'(i), req, rx_d[base+i], seed + 8'(i));
      chk(rx_l[base+i] == (last_at_end && i == len - 1), req, rx_l[base+i],
          (last_at_end && i == len - 1));
    end
  endtask

  initial begin
    int rx0, wb0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!dma_busy && !tx_valid && !srst_busy && !chan_en, "R1 idle flags",
        {dma_busy, tx_valid, srst_busy, chan_en}, 0);
    chk(head_ptr == 0 && cmpl_ptr == 0, "R1 pointers", {head_ptr, cmpl_ptr}, 0);

    regw(4'h4, 1);
    // vector table: single-descriptor packets
    for (int v = 0; v < 6; v++) begin
      int len = int'(VEC[v][31:16]);
      logic [7:0] seed = VEC[v][15:8];
      rmode = int'(VEC[v][7:0]);
      build(32'h100, 0, 32'h200, len, seed, 1);
      rx0 = rx_n; wb0 = wb_n;
      regw(4'h8, 32'h100);
      wait_idle();
      chk(rx_n - rx0 == len, "R3 byte count", rx_n - rx0, len);
      chk_bytes(rx0, len, seed, 1, "R3 byte order/last");
      chk(wb_n - wb0 == 1 && wb_a == 10'(32'h10C >> 2), "R2 R5 writeback address", wb_a, 32'h10C >> 2);
      chk(wb_d == (SE | EOQ | 32'(len)), "R5 writeback mode", wb_d, SE | EOQ | 32'(len));
      chk(head_ptr == 0, "R5 head cleared", head_ptr, 0);
    end
    rmode = 0;

    // R4 backpressure
    chk(stall_err == 0, "R4 stall hold", stall_err, 0);

    // R6 chain of two
    build(32'h100, 32'h140, 32'h200, 6, 8'h60, 1);
    build(32'h140, 0, 32'h400, 5, 8'h90, 1);
    rx0 = rx_n; wb0 = wb_n;
    regw(4'h8, 32'h100);
    wait_idle();
    chk(rx_n - rx0 == 11, "R6 chain bytes", rx_n - rx0, 11);
    chk_bytes(rx0, 6, 8'h60, 1, "R6 first packet");
    chk_bytes(rx0 + 6, 5, 8'h90, 1, "R6 second packet");
    chk(mem[32'h10C >> 2] == (SE | 32'd6), "R6 no eoq on first", mem[32'h10C >> 2], SE | 32'd6);
    chk(mem[32'h14C >> 2] == (SE | EOQ | 32'd5), "R5 eoq on tail", mem[32'h14C >> 2], SE | EOQ | 32'd5);
    chk(wb_n - wb0 == 2 && head_ptr == 0, "R6 two writebacks", wb_n - wb0, 2);

    // R7 not owned
    build(32'h100, 0, 32'h200, 4, 8'h11, 0);
    rx0 = rx_n; wb0 = wb_n;
    regw(4'h8, 32'h100);
    wait_idle();
    chk(rx_n == rx0 && wb_n == wb0, "R7 unowned untouched", rx_n - rx0 + wb_n - wb0, 0);
    chk(head_ptr == 0, "R7 head cleared", head_ptr, 0);

    // R12 zero length
    build(32'h100, 0, 32'h200, 0, 8'h00, 1);
    rx0 = rx_n; wb0 = wb_n;
    regw(4'h8, 32'h100);
    wait_idle();
    chk(rx_n == rx0, "R12 no bytes", rx_n - rx0, 0);
    chk(wb_n - wb0 == 1 && wb_d == (SE | EOQ), "R12 writeback", wb_d, SE | EOQ);

    // R9 enable gates start
    regw(4'h4, 0);
    build(32'h100, 0, 32'h200, 3, 8'h33, 1);
    rx0 = rx_n;
    regw(4'h8, 32'h100);
    repeat (20) @(negedge clk);
    chk(head_ptr == 12'h100 && !dma_busy && rx_n == rx0, "R9 held while disabled", head_ptr, 32'h100);
    regw(4'h4, 1);
    wait_idle();
    chk(rx_n - rx0 == 3 && head_ptr == 0, "R9 runs once enabled", rx_n - rx0, 3);

    // R8 head write ignored while busy, accepted when idle
    rmode = 3;
    build(32'h100, 0, 32'h200, 8, 8'h70, 1);
    rx0 = rx_n;
    regw(4'h8, 32'h100);
    repeat (10) @(negedge clk);
    regw(4'h8, 32'h300);
    chk(dma_busy && head_ptr == 12'h100, "R8 ignored while busy", head_ptr, 32'h100);
    rmode = 0;
    wait_idle();
    chk_bytes(rx0, 8, 8'h70, 1, "R8 original chain kept");
    build(32'h300, 0, 32'h500, 2, 8'hA0, 1);
    rx0 = rx_n;
    regw(4'h8, 32'h300);
    wait_idle();
    chk(rx_n - rx0 == 2 && rx_d[rx0] == 8'hA0, "R8 restart after eoq", rx_n - rx0, 2);

    // R11 completion pointer
    regw(4'hC, 32'h140);
    chk(cmpl_ptr == 12'h140, "R11 completion pointer", cmpl_ptr, 32'h140);
    @(negedge clk);
    chk(cmpl_ptr == 12'h140, "R11 completion held", cmpl_ptr, 32'h140);

    // R10 soft reset mid-packet
    rmode = 3;
    build(32'h100, 0, 32'h200, 9, 8'h20, 1);
    regw(4'h8, 32'h100);
    repeat (10) @(negedge clk);
    chk(tx_valid && dma_busy, "R10 packet in flight", {tx_valid, dma_busy}, 3);
    regw(4'h0, 1);
    chk(srst_busy, "R10 soft reset flag", srst_busy, 1);
    @(negedge clk);
    chk(!srst_busy && !dma_busy && !tx_valid, "R10 aborted and self-cleared",
        {srst_busy, dma_busy, tx_valid}, 0);
    chk(head_ptr == 0 && cmpl_ptr == 0 && !chan_en, "R10 registers cleared",
        {head_ptr, cmpl_ptr, chan_en}, 0);
    rmode = 0;
    repeat (5) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule